// File: doc/BRIEF.md
# Strobed Input Handshake Port

This block is an input port for one group of a parallel interface, with a strobe handshake. A peripheral presents a byte on the data pins and pulls an active-low strobe. The port synchronizes the strobe and captures the byte on its falling edge. It then raises a buffer-full flag. The flag tells the peripheral to hold its next byte until the CPU has taken the current one.

When the interrupt enable is set, the port also raises an interrupt request once the strobe has returned high. A one-cycle CPU read pulse takes the byte and clears both flags. The interrupt enable has no register of its own. It is written with a single-bit set/reset command that addresses the strobe's bit position in the group's status word. The status word shows the live levels of the group's handshake signals.

A parameter picks the group layout, upper or lower. The upper layout also provides two spare lines. A direction input makes them either status inputs or control outputs, and the outputs are driven from latches that bit set/reset commands write.

Top module: `strb_in_port`

## Requirements
- R1: After reset the buffer-full flag and the interrupt request are 0, the interrupt enable is clear, and the captured byte is 0x00.
- R2: A high-to-low transition of the synchronized strobe loads the data pins into the captured byte and sets the buffer-full flag.
- R3: A strobe held low captures only once. Data pin changes during a held-low strobe leave the captured byte unchanged, and a read during it clears the buffer-full flag, which stays clear.
- R4: A read pulse with no capture in the same cycle clears the buffer-full flag and the interrupt request in the next cycle. The captured byte is kept.
- R5: The interrupt request is 1 exactly when the buffer-full flag is set, the interrupt enable is set and the synchronized strobe is high. While the strobe is still low it stays 0.
- R6: A set/reset command (bsr_sel = bit index, bsr_val = new value) aimed at the strobe's bit position writes the interrupt enable. That position is 4 in the upper group and 2 in the lower group. A command to any other index leaves the enable unchanged.
- R7: When a read pulse and a capture fall in the same cycle, the capture wins: the new byte is loaded and the buffer-full flag stays 1.
- R8: The upper group status word carries the strobe level in bit 4, buffer-full in bit 5, interrupt request in bit 3, the spare lines in bits 7:6, and 0 elsewhere.
- R9: In the upper group, spare lines are inputs when spare_dir is 1: their output enables are 0 and status bits 7:6 show spare_in. When spare_dir is 0 both enables are 1, and spare_out bits 0 and 1 hold the values last written by set/reset commands to indices 6 and 7. Status bits 7:6 then show those values.
- R10: In the lower group the status word carries the strobe level in bit 2, buffer-full in bit 1, interrupt request in bit 0, and 0 elsewhere. The spare outputs and their enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_data | input | DATA_W | Peripheral data lines |
| pin_stb_n | input | 1 | Active-low peripheral strobe, asynchronous |
| rd_port | input | 1 | One-cycle CPU read of the captured byte |
| bsr_wr | input | 1 | Bit set/reset command valid |
| bsr_sel | input | 3 | Bit index addressed by the command |
| bsr_val | input | 1 | Value written by the command |
| spare_dir | input | 1 | Spare line direction, 1 = input |
| spare_in | input | 2 | Spare line input levels |
| data_q | output | DATA_W | Captured byte |
| ibf | output | 1 | Input buffer full |
| intr | output | 1 | Interrupt request |
| status | output | 8 | Live status word of the group |
| spare_out | output | 2 | Spare line output values |
| spare_oe | output | 2 | Spare line output enables |

## Verification
The bench drives several single strobe pulses with distinct byte values. These separate a real capture from a stale byte, and they check the enable states. One strobe is held low across a read and a data change, which shows whether edge detection replaced level sensing. One read is placed on the exact capture cycle to check the capture priority. Commands are sent to both the strobe's index and a neighbouring index, which shows whether the bit decode uses the wrong position.

// File: rtl/strb_pkg.sv
package strb_pkg;

   localparam int STAT_W = 8;
   localparam int SEL_W  = 3;

   function automatic int stb_pos(input bit upper);
      return upper ? 4 : 2;
   endfunction

   function automatic int ibf_pos(input bit upper);
      return upper ? 5 : 1;
   endfunction

   function automatic int irq_pos(input bit upper);
      return upper ? 3 : 0;
   endfunction

   localparam int SPARE_LO_POS = 6;
   localparam int SPARE_HI_POS = 7;

   typedef struct packed {
      logic lvl;
      logic ibf;
      logic irq;
   } hs_view_t;

endpackage

// File: rtl/strb_sync.sv
module strb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb_n_i,
   output logic lvl_o,
   output logic fall_o
);

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("strb_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         prev_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], stb_n_i};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign lvl_o  = sync_q[STAGES-1];
   assign fall_o = prev_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/strb_flags.sv
module strb_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic cap_i,
   input  logic rd_i,
   input  logic en_hit_i,
   input  logic en_val_i,
   input  logic lvl_i,
   output logic ibf_o,
   output logic inte_o,
   output logic irq_o
);

   logic ibf_q;
   logic inte_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ibf_q <= 1'b0;
      end else if (cap_i) begin
         ibf_q <= 1'b1;
      end else if (rd_i) begin
         ibf_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inte_q <= 1'b0;
      end else if (en_hit_i) begin
         inte_q <= en_val_i;
      end
   end

   assign ibf_o  = ibf_q;
   assign inte_o = inte_q;
   assign irq_o  = ibf_q & inte_q & lvl_i;

endmodule

// File: rtl/strb_spare.sv
module strb_spare
   import strb_pkg::*;
#(
   parameter bit ENABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bsr_wr,
   input  logic [SEL_W-1:0] bsr_sel,
   input  logic             bsr_val,
   input  logic             dir_in,
   input  logic [1:0]       pins_in,
   output logic [1:0]       pins_out,
   output logic [1:0]       pins_oe,
   output logic [1:0]       lvl_o
);

   generate
      if (ENABLE) begin : g_spare
         logic [1:0] lat_q;

         for (genvar i = 0; i < 2; i++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  lat_q[i] <= 1'b0;
               end else if (bsr_wr && bsr_sel == SEL_W'(SPARE_LO_POS + i)) begin
                  lat_q[i] <= bsr_val;
               end
            end
         end

         assign pins_out = lat_q;
         assign pins_oe  = dir_in ? 2'b00 : 2'b11;
         assign lvl_o    = dir_in ? pins_in : lat_q;
      end else begin : g_none
         assign pins_out = 2'b00;
         assign pins_oe  = 2'b00;
         assign lvl_o    = 2'b00;
      end
   endgenerate

endmodule

// File: rtl/strb_in_port.sv
module strb_in_port
   import strb_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit UPPER_GROUP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] pin_data,
   input  logic              pin_stb_n,
   input  logic              rd_port,
   input  logic              bsr_wr,
   input  logic [2:0]        bsr_sel,
   input  logic              bsr_val,
   input  logic              spare_dir,
   input  logic [1:0]        spare_in,
   output logic [DATA_W-1:0] data_q,
   output logic              ibf,
   output logic              intr,
   output logic [7:0]        status,
   output logic [1:0]        spare_out,
   output logic [1:0]        spare_oe
);

   localparam int STB_POS = stb_pos(UPPER_GROUP);
   localparam int IBF_POS = ibf_pos(UPPER_GROUP);
   localparam int IRQ_POS = irq_pos(UPPER_GROUP);

   generate
      if (DATA_W < 1) begin : g_bad_w
         $error("strb_in_port: DATA_W must be positive");
      end
   endgenerate

   logic             lvl_w;
   logic             cap_w;
   logic             inte_w;
   logic             en_hit_w;
   logic [1:0]       spare_lvl_w;
   logic [DATA_W-1:0] data_r;
   hs_view_t         view_w;

   strb_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .stb_n_i (pin_stb_n),
      .lvl_o   (lvl_w),
      .fall_o  (cap_w)
   );

   assign en_hit_w = bsr_wr && (bsr_sel == SEL_W'(STB_POS));

   strb_flags u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_i    (cap_w),
      .rd_i     (rd_port),
      .en_hit_i (en_hit_w),
      .en_val_i (bsr_val),
      .lvl_i    (lvl_w),
      .ibf_o    (ibf),
      .inte_o   (inte_w),
      .irq_o    (intr)
   );

   strb_spare #(.ENABLE(UPPER_GROUP)) u_spare (
      .clk      (clk),
      .rst_n    (rst_n),
      .bsr_wr   (bsr_wr),
      .bsr_sel  (bsr_sel),
      .bsr_val  (bsr_val),
      .dir_in   (spare_dir),
      .pins_in  (spare_in),
      .pins_out (spare_out),
      .pins_oe  (spare_oe),
      .lvl_o    (spare_lvl_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_r <= '0;
      end else if (cap_w) begin
         data_r <= pin_data;
      end
   end

   assign data_q = data_r;

   assign view_w = '{lvl: lvl_w, ibf: ibf, irq: intr};

   always_comb begin
      status          = '0;
      status[STB_POS] = view_w.lvl;
      status[IBF_POS] = view_w.ibf;
      status[IRQ_POS] = view_w.irq;
      if (UPPER_GROUP) begin
         status[SPARE_HI_POS:SPARE_LO_POS] = spare_lvl_w;
      end
   end

endmodule

// File: rtl/strb_in_port_chk.sv
module strb_in_port_chk
   import strb_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter bit UPPER_GROUP = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] pin_data,
   input logic              rd_port,
   input logic              bsr_wr,
   input logic [2:0]        bsr_sel,
   input logic              bsr_val,
   input logic [DATA_W-1:0] data_q,
   input logic              ibf,
   input logic              intr,
   input logic [7:0]        status,
   input logic              cap_w,
   input logic              inte_w,
   input logic              lvl_w
);

   localparam int STB_POS = stb_pos(UPPER_GROUP);
   localparam int IBF_POS = ibf_pos(UPPER_GROUP);

   AST_CAP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      cap_w |=> (ibf && data_q == $past(pin_data)));                 // R2

   AST_SINGLE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      cap_w |=> !cap_w);                                              // R3

   AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_port && !cap_w) |=> (!ibf && !intr));                       // R4

   AST_IRQ_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      intr |-> (ibf && inte_w && lvl_w));                             // R5

   AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bsr_wr && bsr_sel == 3'(STB_POS)) |=> (inte_w == $past(bsr_val))); // R6

   AST_CAP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_port && cap_w) |=> ibf);                                    // R7

   AST_STATUS_IBF: assert property (@(posedge clk) disable iff (!rst_n)
      status[IBF_POS] == ibf);                                        // R8

endmodule

bind strb_in_port strb_in_port_chk #(
   .DATA_W      (DATA_W),
   .UPPER_GROUP (UPPER_GROUP)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pin_data (pin_data),
   .rd_port  (rd_port),
   .bsr_wr   (bsr_wr),
   .bsr_sel  (bsr_sel),
   .bsr_val  (bsr_val),
   .data_q   (data_q),
   .ibf      (ibf),
   .intr     (intr),
   .status   (status),
   .cap_w    (cap_w),
   .inte_w   (inte_w),
   .lvl_w    (lvl_w)
);

// File: tb/sim_strb_in_port.sv
`timescale 1ns/1ps
module sim_strb_in_port;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] pin_data = '0;
   logic       stb_n = 1'b1;
   logic       rd = 1'b0;
   logic       bwr = 1'b0;
   logic [2:0] bsel = '0;
   logic       bval = 1'b0;
   logic       sdir = 1'b1;
   logic [1:0] sin = 2'b00;
   logic [7:0] data_q;
   logic       ibf, intr;
   logic [7:0] status;
   logic [1:0] sout, soe;

   logic [7:0] l_data = '0;
   logic       l_stb_n = 1'b1;
   logic       l_rd = 1'b0;
   logic       l_bwr = 1'b0;
   logic [2:0] l_bsel = '0;
   logic       l_bval = 1'b0;
   logic [7:0] l_q;
   logic       l_ibf, l_intr;
   logic [7:0] l_status;
   logic [1:0] l_sout, l_soe;

   int total = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   strb_in_port #(.UPPER_GROUP(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .pin_data(pin_data), .pin_stb_n(stb_n),
      .rd_port(rd), .bsr_wr(bwr), .bsr_sel(bsel), .bsr_val(bval),
      .spare_dir(sdir), .spare_in(sin), .data_q(data_q), .ibf(ibf),
      .intr(intr), .status(status), .spare_out(sout), .spare_oe(soe)
   );

   strb_in_port #(.UPPER_GROUP(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .pin_data(l_data), .pin_stb_n(l_stb_n),
      .rd_port(l_rd), .bsr_wr(l_bwr), .bsr_sel(l_bsel), .bsr_val(l_bval),
      .spare_dir(1'b0), .spare_in(2'b11), .data_q(l_q), .ibf(l_ibf),
      .intr(l_intr), .status(l_status), .spare_out(l_sout), .spare_oe(l_soe)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic bsr(input logic [2:0] sel, input logic val);
      @(negedge clk);
      bwr = 1'b1; bsel = sel; bval = val;
      @(negedge clk);
      bwr = 1'b0;
   endtask

   task automatic read_pulse();
      @(negedge clk);
      rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic strobe(input logic [7:0] b, input int exp_irq);
      @(negedge clk);
      stb_n = 1'b0; pin_data = b;
      tick(4);
      check("R2 ibf after strobe", ibf, 1);
      check("R2 captured byte", data_q, b);
      check("R5 irq low while strobe low", intr, 0);
      stb_n = 1'b1;
      tick(4);
      check("R5 irq after strobe release", intr, exp_irq);
   endtask

   task automatic t_reset();
      tick(1);
      check("R1 ibf", ibf, 0);
      check("R1 irq", intr, 0);
      check("R1 byte", data_q, 0);
      check("R8 status at reset", status, 8'h10);
   endtask

   task automatic t_read();
      strobe(8'hA5, 0);
      check("R8 status with ibf", status, 8'h30);
      read_pulse();
      check("R4 ibf cleared", ibf, 0);
      check("R4 byte kept", data_q, 8'hA5);
   endtask

   task automatic t_enable();
      bsr(3'd3, 1'b1);
      strobe(8'h3C, 0);   // R6 wrong index leaves enable clear
      read_pulse();
      bsr(3'd4, 1'b1);
      strobe(8'h5A, 1);   // R6 enable set at index 4
      check("R8 status with irq", status, 8'h38);
      read_pulse();
      check("R4 irq cleared", intr, 0);
      check("R4 ibf cleared after irq", ibf, 0);
      bsr(3'd5, 1'b0);
      strobe(8'h66, 1);   // R6 neighbour index keeps enable set
      read_pulse();
      bsr(3'd4, 1'b0);
      strobe(8'h11, 0);   // R6 enable cleared
      read_pulse();
   endtask

   task automatic t_held();
      @(negedge clk);
      stb_n = 1'b0; pin_data = 8'h77;
      tick(4);
      check("R3 first capture", data_q, 8'h77);
      read_pulse();
      tick(6);
      check("R3 no recapture while held", ibf, 0);
      pin_data = 8'h88;
      tick(4);
      check("R3 byte unchanged while held", data_q, 8'h77);
      stb_n = 1'b1;
      tick(4);
      check("R3 release does not capture", ibf, 0);
   endtask

   task automatic t_coincide();
      strobe(8'h01, 0);
      @(negedge clk);
      stb_n = 1'b0; pin_data = 8'h02;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
      check("R7 ibf kept on collision", ibf, 1);
      check("R7 new byte on collision", data_q, 8'h02);
      stb_n = 1'b1;
      tick(4);
      read_pulse();
   endtask

   task automatic t_spare();
      sdir = 1'b1; sin = 2'b10;
      tick(1);
      check("R9 input enables", soe, 0);
      check("R9 status shows inputs", status[7:6], 2'b10);
      bsr(3'd6, 1'b1);
      bsr(3'd7, 1'b0);
      sdir = 1'b0;
      tick(1);
      check("R9 output enables", soe, 3);
      check("R9 output latches", sout, 2'b01);
      check("R9 status shows latches", status[7:6], 2'b01);
   endtask

   task automatic t_lower();
      check("R10 lower reset status", l_status, 8'h04);
      check("R10 lower spare off", {l_sout, l_soe}, 0);
      @(negedge clk);
      l_bwr = 1'b1; l_bsel = 3'd2; l_bval = 1'b1;
      @(negedge clk);
      l_bwr = 1'b0;
      l_stb_n = 1'b0; l_data = 8'hC3;
      tick(4);
      check("R10 lower capture", l_q, 8'hC3);
      check("R10 lower status strobe low", l_status, 8'h02);
      l_stb_n = 1'b1;
      tick(4);
      check("R6 lower enable at index 2", l_intr, 1);
      check("R10 lower status full", l_status, 8'h07);
      @(negedge clk);
      l_rd = 1'b1;
      @(negedge clk);
      l_rd = 1'b0;
      check("R10 lower status after read", l_status, 8'h04);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      t_reset();
      t_read();
      t_enable();
      t_held();
      t_coincide();
      t_spare();
      t_lower();
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

endmodule